// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps one status slot for each received frame that sits in a receive buffer, and shows the host the 16-bit status word of the oldest one. The receiver reports each frame with a start pulse, then a finish pulse that carries the byte count and a 4-bit error-type code. The finish pulse turns the frame's slot from incomplete into complete. The host reads the status word and the completion flag. After it has drained a frame's data, it pulses the discard input, and the next frame moves to the top.

The queue holds eight frames. While it is full, the overrun flag is high and a new frame start is refused. The frame that was refused leaves no trace, and that includes its finish pulse. Removing one frame clears the flag. A byte count above 1514 is classed as oversize by the block itself. A receive reset empties the queue.

A small state machine tracks the frame now on the wire. Its states are S_IDLE (no frame in progress), S_RECV (the frame holds a slot and is incomplete) and S_DROP (the frame was refused and its finish is awaited). Its transitions are:
- T_ACCEPT, S_IDLE to S_RECV: a start arrives and there is room.
- T_REJECT, S_IDLE to S_DROP: a start arrives and the queue is full.
- T_FINISH, S_RECV to S_IDLE: the finish pulse stores the status.
- T_DROP_END, S_DROP to S_IDLE: the finish pulse is swallowed.
- T_CLEAR, any state to S_IDLE: receive reset.

Top module: `rx_status_queue`

## Requirements
- R1: `status_word` is `{incomplete[15], code[14:11], length[10:0]}`. When the queue is empty, or its oldest frame is still incomplete, the word is exactly 16'h8000.
- R2: For a completed oldest frame, bit 15 is 0, bits 14..11 carry the receiver's error code and bits 10..0 the byte count. The codes are 0000 good, 1000 overrun, 1011 runt, 1100 alignment, 1101 CRC and 0010 dribble; bit 14 set means the frame has an error.
- R3: A byte count above 1514 is stored with code 1001, whatever code the receiver gave.
- R4: `status_overrun` is high exactly while eight frames are queued. A `frm_start` seen then is refused, unless a discard takes effect in the same cycle.
- R5: The `frm_done` of a refused frame adds no entry.
- R6: `discard_top` removes the oldest frame when that frame is complete. It is ignored when the queue is empty or the oldest frame is incomplete. Frames leave in arrival order.
- R7: After one removal from a full queue, `status_overrun` falls, and the next start is accepted.
- R8: `rx_complete` is high exactly while the oldest queued frame is complete.
- R9: `rx_reset` empties the queue, clears overrun and abandons any frame in progress.
- R10: A discard in the same cycle as a finish, or as a start, applies both, and the frame count stays consistent.
- R11: `frm_start` while a frame is in progress, and `frm_done` with no frame in progress, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive reset: empties the queue |
| frm_start | input | 1 | Receiver begins a frame |
| frm_done | input | 1 | Receiver finished the frame |
| frm_len | input | 11 | Byte count, valid with frm_done |
| frm_err | input | 4 | Error-type code, valid with frm_done |
| discard_top | input | 1 | Remove the oldest complete frame |
| status_word | output | 16 | Status of the oldest frame |
| rx_complete | output | 1 | The oldest frame is complete |
| status_overrun | output | 1 | Queue holds eight frames |

## Verification
The assertions check four things on every cycle:
- The slot count never passes eight, and a full queue with no discard stays full.
- Every stored finish has a slot to land in.
- The completion flag never shows alongside an incomplete word, and a stored length above 1514 always carries code 1001.
- A receive reset leaves the empty word.

Only the bench's scenarios can show the rest: the arrival order of the frames as they leave, the finish pulse of a refused frame being swallowed, and the same-cycle discard cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int LEN_W  = 11;
    localparam int CODE_W = 4;
    localparam int STAT_W = 1 + CODE_W + LEN_W;

    localparam logic [CODE_W-1:0] CODE_OVERSIZE = 4'b1001;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RECV = 2'd1,
        S_DROP = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic              done;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_frame_fsm.sv
module rxq_frame_fsm
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic done,
    input  logic room,
    output logic alloc,
    output logic fill
);
    rx_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (start) state_nxt = room ? S_RECV : S_DROP;   // T_ACCEPT / T_REJECT
            S_RECV: if (done)  state_nxt = S_IDLE;                   // T_FINISH
            S_DROP: if (done)  state_nxt = S_IDLE;                   // T_DROP_END
            default:           state_nxt = S_IDLE;
        endcase
        if (clr) state_nxt = S_IDLE;                                 // T_CLEAR
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        alloc = 1'b0;
        fill  = 1'b0;
        unique case (state)
            S_IDLE: alloc = start && room && !clr;
            S_RECV: fill  = done && !clr;
            S_DROP: ;
            default: ;
        endcase
    end

    // R5: a refused frame ends without touching the queue
    p_drop_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP && done) |=> (state == S_IDLE));
    // R11: a frame in progress blocks a second start
    p_one_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECV && !done && !clr) |=> (state == S_RECV));
endmodule

// File: rtl/rxq_status_ring.sv
module rxq_status_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             alloc,
    input  logic             fill,
    input  rxq_entry_t       fill_entry,
    input  logic             discard,
    output rxq_entry_t       top,
    output logic [CNT_W-1:0] count,
    output logic             pop
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] head, tail, newest;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign newest = (tail == '0) ? LAST_IDX : tail - PTR_W'(1);
    assign top    = mem[head];
    assign pop    = discard && (count != '0) && mem[head].done && !clr;

    always_ff @(posedge clk) begin
        if (alloc)     mem[tail]   <= '0;
        else if (fill) mem[newest] <= fill_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc) tail <= wrap_inc(tail);
            if (pop)   head <= wrap_inc(head);
            unique case ({alloc, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R4: never more than DEPTH slots
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && !pop) |-> !alloc);
    // R2: a finish always lands in an allocated slot
    p_fill_has_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> (count != '0));
    // R9: clear empties the ring
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R10: removal with a simultaneous allocation keeps the count
    p_count_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && pop) |=> $stable(count));
endmodule

// File: rtl/rxq_status_fmt.sv
module rxq_status_fmt
    import rxq_pkg::*;
#(
    parameter int MAX_LEN = 1514
) (
    input  logic [LEN_W-1:0]  in_len,
    input  logic [CODE_W-1:0] in_code,
    input  rxq_entry_t        top,
    input  logic              have_entry,
    output rxq_entry_t        store_entry,
    output logic [STAT_W-1:0] status_word,
    output logic              top_ready
);
    logic oversize;

    assign oversize = (int'(in_len) > MAX_LEN);

    always_comb begin
        store_entry.done = 1'b1;
        store_entry.len  = in_len;
        store_entry.code = oversize ? CODE_OVERSIZE : in_code;
    end

    assign top_ready = have_entry && top.done;

    always_comb begin
        if (top_ready) status_word = {1'b0, top.code, top.len};
        else           status_word = {1'b1, {(STAT_W-1){1'b0}}};
    end
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MAX_LEN = 1514
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              frm_start,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [CODE_W-1:0] frm_err,
    input  logic              discard_top,
    output logic [STAT_W-1:0] status_word,
    output logic              rx_complete,
    output logic              status_overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic             alloc, fill, pop, room;
    logic [CNT_W-1:0] count;
    rxq_entry_t       top, store_entry;

    assign room           = (count != FULL_CNT) || pop;
    assign status_overrun = (count == FULL_CNT);

    rxq_frame_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_reset),
        .start (frm_start),
        .done  (frm_done),
        .room  (room),
        .alloc (alloc),
        .fill  (fill)
    );

    rxq_status_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (rx_reset),
        .alloc      (alloc),
        .fill       (fill),
        .fill_entry (store_entry),
        .discard    (discard_top),
        .top        (top),
        .count      (count),
        .pop        (pop)
    );

    rxq_status_fmt #(.MAX_LEN(MAX_LEN)) u_fmt (
        .in_len      (frm_len),
        .in_code     (frm_err),
        .top         (top),
        .have_entry  (count != '0),
        .store_entry (store_entry),
        .status_word (status_word),
        .top_ready   (rx_complete)
    );

    // R4: a full queue stays full without a discard
    p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_overrun && !discard_top && !rx_reset) |=> status_overrun);
    // R8: completion flag never shows with an incomplete word
    p_complete_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !status_word[STAT_W-1]);
    // R3: an oversize length always carries the oversize code
    p_oversize_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_complete && int'(status_word[LEN_W-1:0]) > MAX_LEN)
            |-> (status_word[STAT_W-2:LEN_W] == CODE_OVERSIZE));
    // R9: receive reset returns to the empty word
    p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (status_word == 16'h8000 && !status_overrun && !rx_complete));
endmodule

// File: tb/test_rx_status_queue.sv
`timescale 1ns/1ps
module test_rx_status_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_reset = 1'b0, frm_start = 1'b0, frm_done = 1'b0, discard_top = 1'b0;
    logic [10:0] frm_len = '0;
    logic [3:0]  frm_err = '0;
    logic [15:0] status_word;
    logic        rx_complete, status_overrun;

    int checks = 0;
    int errors = 0;

    // bench model: completed words in order, plus state of frame on the wire
    logic [15:0] mq[$];
    int          mst = 0;   // 0 idle, 1 receiving, 2 refused

    always #2 clk = ~clk;

    rx_status_queue i_rx_status_queue (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .frm_start(frm_start),
        .frm_done(frm_done), .frm_len(frm_len), .frm_err(frm_err),
        .discard_top(discard_top), .status_word(status_word),
        .rx_complete(rx_complete), .status_overrun(status_overrun)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int total = mq.size() + ((mst == 1) ? 1 : 0);
        chk(tag, "status_word", int'(status_word), (mq.size() > 0) ? int'(mq[0]) : 'h8000);
        chk(tag, "rx_complete", int'(rx_complete), (mq.size() > 0) ? 1 : 0);
        chk(tag, "status_overrun", int'(status_overrun), (total == 8) ? 1 : 0);
    endtask

    task automatic step(input logic s, input logic d, input int l, input int e,
                        input logic x, input logic r, input string tag);
        frm_start = s; frm_done = d; frm_len = 11'(l); frm_err = 4'(e);
        discard_top = x; rx_reset = r;
        @(posedge clk);
        if (r) begin
            mq.delete(); mst = 0;
        end else begin
            int  total = mq.size() + ((mst == 1) ? 1 : 0);
            bit  pop   = x && (mq.size() > 0);
            int  nst   = mst;
            if (mst == 0 && s)      nst = (total < 8 || pop) ? 1 : 2;
            else if (mst != 0 && d) nst = 0;
            if (pop) void'(mq.pop_front());
            if (mst == 1 && d)
                mq.push_back({1'b0, (l > 1514) ? 4'b1001 : 4'(e), 11'(l)});
            mst = nst;
        end
        @(negedge clk);
        frm_start = 0; frm_done = 0; discard_top = 0; rx_reset = 0;
        compare(tag);
    endtask

    task automatic frame(input int l, input int e, input string tag);
        step(1, 0, 0, 0, 0, 0, tag);
        step(0, 1, l, e, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int codes[6] = '{0, 8, 11, 12, 13, 2};
        int lens[4]  = '{0, 64, 1000, 1514};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        // R2: every receiver code against several lengths
        foreach (codes[c]) foreach (lens[k]) begin
            step(1, 0, 0, 0, 0, 0, "R1 incomplete top");
            step(0, 1, lens[k], codes[c], 0, 0, "R2 stored status");
            step(0, 0, 0, 0, 1, 0, "R6 discard");
        end
        // R3: oversize override
        for (int l = 1510; l < 1520; l++) begin
            frame(l, l % 16, "R3 oversize boundary");
            step(0, 0, 0, 0, 1, 0, "R6 discard");
        end
        frame(2047, 13, "R3 oversize max");
        step(0, 0, 0, 0, 1, 0, "R6 discard");
        // R4/R5: fill to eight, refused frame and its finish
        for (int i = 0; i < 8; i++) frame(100 + i, (i % 2) ? 12 : 0, "R4 fill");
        step(1, 0, 0, 0, 0, 0, "R4 refused start");
        step(0, 1, 77, 8, 0, 0, "R5 refused finish ignored");
        step(0, 0, 0, 0, 1, 0, "R7 overrun clears");
        frame(200, 11, "R7 start accepted after removal");
        // R10: full plus discard and start in same cycle
        step(1, 0, 0, 0, 1, 0, "R10 start with discard at full");
        step(0, 1, 300, 2, 1, 0, "R10 finish with discard");
        for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, 0, "R6 drain order");
        // R6: discard when empty or top incomplete
        step(0, 0, 0, 0, 1, 0, "R6 discard empty");
        step(1, 0, 0, 0, 0, 0, "R11 start");
        step(0, 0, 0, 0, 1, 0, "R6 discard incomplete top");
        step(1, 0, 0, 0, 0, 0, "R11 second start ignored");
        step(0, 1, 55, 0, 0, 0, "R11 finish");
        step(0, 1, 66, 0, 0, 0, "R11 idle finish ignored");
        step(0, 0, 0, 0, 1, 0, "R6 discard");
        // R9: reset mid-frame and with a full queue
        frame(10, 0, "R9 setup");
        step(1, 0, 0, 0, 0, 0, "R9 setup");
        step(0, 0, 0, 0, 0, 1, "R9 receive reset");
        step(0, 1, 20, 0, 0, 0, "R9 abandoned finish ignored");
        for (int i = 0; i < 8; i++) frame(i, 0, "R4 refill");
        step(0, 0, 0, 0, 0, 1, "R9 reset clears overrun");
        frame(33, 13, "R8 after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule